// File: doc/BRIEF.md
# Bidirectional Latched-Registered Bus Transceiver

This block moves 18-bit words between two buses, called side A and side B, along two data paths that do not share any control. The A-to-B path takes `a_in` to `b_out`. The B-to-A path takes `b_in` to `a_out`. Each path has three controls: a latch-enable, its own data clock and an output enable. Each path works in one of three modes, chosen every system cycle from these controls:

- **MODE_PASS**: the latch-enable is high, so the path is transparent.
- **MODE_HOLD**: the latch-enable is low and the data clock has no rising edge, so the stored word stays.
- **MODE_CAPTURE**: the latch-enable is low and the data clock rises, so the input word is loaded.

The whole block runs on one system clock. It finds a rising edge on a path's data clock by comparing the present sample with the sample registered one system cycle earlier.

For each path, the state register holds two things: the stored word and the previous data-clock sample. The mode sets the next state:

- From any mode, **MODE_PASS** and **MODE_CAPTURE** load the input word.
- **MODE_HOLD** keeps the stored word.

The output process gives the input word in MODE_PASS and the stored word otherwise. Each output side also gives a drive-enable, so that a pad wrapper can build tri-state pins from it. The A-to-B enable is active high. The B-to-A enable is active low.

Top module: `bus_xcvr`

## Requirements
- R1: Both paths are 18 bits wide and fully independent. The controls and data of one path never change the output of the other path.
- R2: While a path's latch-enable is 1 (MODE_PASS), its output equals its input word in the same cycle, with no register delay.
- R3: While the latch-enable is 0 and the data clock shows no 0-to-1 change between two consecutive system-clock samples (MODE_HOLD), the output stays unchanged, whatever the input word does.
- R4: While the latch-enable is 0, a data clock sampled 0 and then 1 on consecutive system edges causes MODE_CAPTURE. The input word present at the edge where 1 is sampled appears on the output from the next cycle.
- R5: After the latch-enable falls from 1 to 0, the output holds the last word that passed through in MODE_PASS.
- R6: `b_drive` is 1 exactly when `ab_oe` is 1 (active high).
- R7: `a_drive` is 1 exactly when `ba_oe_n` is 0 (active low).
- R8: The output enables change only the drive-enables. A word stored while the drive is off appears unchanged when the drive comes back on.
- R9: A synchronous reset (`rst` = 1 at a rising edge of `clk`) clears both stored words and both previous data-clock samples to 0.
- R10: A data-clock rising edge that comes while the latch-enable is 1 is handled as MODE_PASS. The word stored is the word that passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word from side A |
| ab_le | input | 1 | A-to-B latch-enable |
| ab_clk | input | 1 | A-to-B data clock |
| ab_oe | input | 1 | A-to-B output enable, active high |
| b_out | output | 18 | Word toward side B |
| b_drive | output | 1 | Drive-enable for side B |
| b_in | input | 18 | Word from side B |
| ba_le | input | 1 | B-to-A latch-enable |
| ba_clk | input | 1 | B-to-A data clock |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Word toward side A |
| a_drive | output | 1 | Drive-enable for side A |

## Verification
The assertions take for granted the following about the inputs:

- The data clocks are ordinary synchronous inputs that are held low while reset is asserted. If a data clock were high when reset is released, the cleared previous sample would turn that level into a capture, and the hold property would no longer apply.
- The assertions also expect each data-clock level to last at least one system cycle.

The stimulus keeps within these rules. It changes every input on the falling edge of `clk`, keeps both data clocks at 0 through every reset, and holds each data-clock level for at least one whole system cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned XCVR_WIDTH = 18;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } lane_mode_t;

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sig;
        end
    end

    assign rise = sig & ~prev_q;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int unsigned W          = 18,
    parameter bit          OE_ACT_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic         dclk,
    input  logic         oe,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    import xcvr_pkg::*;

    lane_mode_t   mode;
    logic         dclk_rise;
    logic [W-1:0] store_q;

    xcvr_rise_det u_rise (
        .clk  (clk),
        .rst  (rst),
        .sig  (dclk),
        .rise (dclk_rise)
    );

    // Mode select: transparency wins over a coincident edge (R10)
    always_comb begin
        if (le) begin
            mode = MODE_PASS;
        end else if (dclk_rise) begin
            mode = MODE_CAPTURE;
        end else begin
            mode = MODE_HOLD;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                MODE_PASS:    store_q <= din;
                MODE_CAPTURE: store_q <= din;
                MODE_HOLD:    store_q <= store_q;
                default:      store_q <= store_q;
            endcase
        end
    end

    // Output process
    always_comb begin
        unique case (mode)
            MODE_PASS: dout = din;
            default:   dout = store_q;
        endcase
    end

    generate
        if (OE_ACT_LOW) begin : g_oe_low
            assign drive = ~oe;
        end else begin : g_oe_high
            assign drive = oe;
        end
    endgenerate

    // R3: no edge while latched -> output frozen
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!le && $past(!le) && $past(dclk) == $past(dclk, 2)) |-> dout == $past(dout))
        else $error("p_hold_r3");

    // R4: edge seen while latched -> input of that cycle appears next cycle
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (!le && $past(!le && $rose(dclk))) |-> dout == $past(din))
        else $error("p_capture_r4");

    // R5 / R10: leaving transparency keeps last passed word
    p_hold_after_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (!le && $past(le)) |-> dout == $past(din))
        else $error("p_hold_after_pass_r5");

    // R9: first cycle after reset shows a cleared store
    p_reset_clear_r9: assert property (@(posedge clk)
        ($past(rst) && !rst && !le) |-> dout == '0)
        else $error("p_reset_clear_r9");

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ab_oe,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ba_le,
    input  logic             ba_clk,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);

    xcvr_lane #(.W(WIDTH), .OE_ACT_LOW(1'b0)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .le    (ab_le),
        .dclk  (ab_clk),
        .oe    (ab_oe),
        .din   (a_in),
        .dout  (b_out),
        .drive (b_drive)
    );

    xcvr_lane #(.W(WIDTH), .OE_ACT_LOW(1'b1)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .le    (ba_le),
        .dclk  (ba_clk),
        .oe    (ba_oe_n),
        .din   (b_in),
        .dout  (a_out),
        .drive (a_drive)
    );

    // R6 / R7: drive-enables follow their own enable with opposite polarity
    p_polarity_r6_r7: assert property (@(posedge clk) disable iff (rst)
        (b_drive == ab_oe) && (a_drive == !ba_oe_n))
        else $error("p_polarity_r6_r7");

endmodule

// File: tb/bus_xcvr_bench.sv
module bus_xcvr_bench;

    localparam int W  = 18;
    localparam int NV = 10;

    // {le, dclk, oe, din[17:0], expected out[17:0], expected drive}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b1, 18'h01111, 18'h01111, 1'b1},  // R2 pass
        {1'b0, 1'b0, 1'b1, 18'h02222, 18'h01111, 1'b1},  // R5 hold last passed
        {1'b0, 1'b1, 1'b1, 18'h03333, 18'h01111, 1'b1},  // R4 edge sampled now
        {1'b0, 1'b1, 1'b1, 18'h04444, 18'h03333, 1'b1},  // R4 captured word out
        {1'b0, 1'b0, 1'b0, 18'h05555, 18'h03333, 1'b0},  // R3 hold, drive off
        {1'b0, 1'b0, 1'b0, 18'h06666, 18'h03333, 1'b0},  // R8 hold, drive off
        {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h03333, 1'b1},  // R4 edge, drive back
        {1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA, 1'b1},  // R2 pass
        {1'b1, 1'b1, 1'b1, 18'h20001, 18'h20001, 1'b1},  // R10 edge in pass
        {1'b0, 1'b1, 1'b1, 18'h15555, 18'h20001, 1'b1}   // R10 stored passed word
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
    logic         a_drive, b_drive;
    int           checks = 0;
    int           errors = 0;
    bit           done   = 1'b0;

    always #4 clk = ~clk;

    bus_xcvr u_bus_xcvr (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a_in),
        .ab_le   (ab_le),
        .ab_clk  (ab_clk),
        .ab_oe   (ab_oe),
        .b_out   (b_out),
        .b_drive (b_drive),
        .b_in    (b_in),
        .ba_le   (ba_le),
        .ba_clk  (ba_clk),
        .ba_oe_n (ba_oe_n),
        .a_out   (a_out),
        .a_drive (a_drive)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ab_le = 1'b0; ab_clk = 1'b0; ab_oe = 1'b0;
        ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b1;
        a_in = '0; b_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        do_reset();
        #1;
        check("R9 reset b_out", b_out, '0);
        check("R9 reset a_out", a_out, '0);
        check("R6 reset b_drive", {17'd0, b_drive}, 18'd0);
        check("R7 reset a_drive", {17'd0, a_drive}, 18'd0);

        // Table walk: direction 0 = A-to-B, 1 = B-to-A
        for (int dir = 0; dir < 2; dir++) begin
            do_reset();
            for (int i = 0; i < NV; i++) begin
                @(negedge clk);
                if (dir == 0) begin
                    ab_le = VEC[i][39]; ab_clk = VEC[i][38]; ab_oe = VEC[i][37];
                    a_in  = VEC[i][36:19];
                end else begin
                    ba_le = VEC[i][39]; ba_clk = VEC[i][38]; ba_oe_n = ~VEC[i][37];
                    b_in  = VEC[i][36:19];
                end
                #1;
                if (dir == 0) begin
                    check($sformatf("R1-AB vec%0d data (R2 R3 R4 R5 R10)", i), b_out, VEC[i][18:1]);
                    check($sformatf("R6 vec%0d b_drive", i), {17'd0, b_drive}, {17'd0, VEC[i][0]});
                    check($sformatf("R1 vec%0d a_out idle", i), a_out, '0);
                end else begin
                    check($sformatf("R1-BA vec%0d data (R2 R3 R4 R5 R8)", i), a_out, VEC[i][18:1]);
                    check($sformatf("R7 vec%0d a_drive", i), {17'd0, a_drive}, {17'd0, VEC[i][0]});
                    check($sformatf("R1 vec%0d b_out idle", i), b_out, '0);
                end
            end
        end

        // R1: A-to-B pass does not disturb B-to-A stored word 20001
        @(negedge clk);
        ba_clk = 1'b0;
        ab_le = 1'b1; a_in = 18'h3FFFF; b_in = 18'h00F0F;
        #1;
        check("R1 ab pass", b_out, 18'h3FFFF);
        check("R1 ba holds", a_out, 18'h20001);

        // R3: input wiggle while holding, many cycles
        @(negedge clk);
        ab_le = 1'b0; a_in = 18'h12345;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_in = a_in ^ 18'h3FFFF;
            #1;
            check("R3 hold under input change", b_out, 18'h3FFFF);
        end

        // R8: toggle enables only, stored word survives
        @(negedge clk);
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        @(negedge clk);
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        #1;
        check("R8 b_out after oe toggle", b_out, 18'h3FFFF);
        check("R8 a_out after oe toggle", a_out, 18'h20001);
        check("R7 a_drive low-active on", {17'd0, a_drive}, 18'd1);

        // R9: reset mid-operation clears stores
        do_reset();
        #1;
        check("R9 clear b_out", b_out, '0);
        check("R9 clear a_out", a_out, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule